// File: doc/BRIEF.md
# Token-Based Shared Resource Allocation Manager

This block controls when requesters may use a set of shared, congestion-prone resources. The resources are sixteen memory banks plus the receive and transmit paths of two I/O ports, which gives twenty in all. Each requester belongs to one of four allocation groups. Every group holds its own token bucket for every resource. A requester raises `req_valid` together with a resource index, and holds both until `gnt` answers it. A grant means the requester may send one command to that resource, and the grant spends one token of the requester's group for that resource.

Software sets three things through a small write-only register port: a global enable, the group of each requester, and one refill interval per group. A group with interval N earns one token per resource every N cycles. A bucket holds at most two tokens. Each resource has a congestion input. While that input is high, refills for that resource come at half the normal rate in every group. Inside a group, waiting requesters take turns in rotating order. When several groups could be served in the same cycle, a rotating group pointer picks one of them, so no more than one grant is issued per cycle.

When the enable bit is clear, the block gets out of the way and every request is granted in the cycle it is seen.

Top module: `tok_alloc_mgr`

## Requirements
- R1: With enable clear (control register, address 0, bit 0 = 0), `gnt` equals `req_valid` in the same cycle.
- R2: After reset, enable is clear, every refill interval is 0, every requester is in group 0, every bucket is empty and `gnt` is 0 when nothing is requested.
- R3: With enable set, requester i is granted only while it requests and its group holds at least one token for the resource given by `req_res[5i+4:5i]`. An index of 20 or more is never granted.
- R4: With enable set, at most one `gnt` bit is high in any cycle.
- R5: Writing refill interval N to group g (address 4+g, bits 11:0) restarts that group's refill counting at the write edge. If N > 0, a token is added to every resource of that group on the edges that fall N, 2N, 3N, ... cycles after the write edge. If N = 0, the group earns no tokens.
- R6: A bucket never holds more than 2 tokens. Further refills while it is full are lost.
- R7: A grant removes exactly one token from the bucket for the requester's group and the requested resource, at the next clock edge.
- R8: Inside a group, the search for the next grant starts at the requester just after the one last granted in that group. It runs in ascending index order and wraps around. All pointers start at requester 0.
- R9: While `congest[r]` is high, every second refill event for resource r is skipped, starting with the first event after an interval write. This halves the refill rate for r and leaves the other resources unchanged.
- R10: A write to the group map (address 1, requester i in bits 2i+1:2i) changes grants from the following cycle on. Tokens stay with their group and are not moved by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 8 | Request flag per requester, held until granted |
| req_res | input | 40 | Resource index per requester, 5 bits each |
| congest | input | 20 | Congestion flag per resource |
| gnt | output | 8 | Grant per requester, same cycle as the request |

## Verification
The assertions assume that configuration writes only touch the defined addresses. They also assume that requesters keep `req_valid` and `req_res` steady from one clock edge to the next, and that enable and the interval values are not rewritten in the middle of a measured window. The stimulus meets these conditions by changing inputs only just after a rising edge, and by writing each interval once before its measurement and clearing it to zero afterwards. Refill timing is made deterministic by measuring from the interval write edge, and each window is closed before a refill that would fall on its boundary. Under these conditions the exact order of grants, including round-robin order and halved refills under congestion, can be predicted and compared.

// File: rtl/tam_pkg.sv
package tam_pkg;

    // Configuration register addresses
    localparam int unsigned TAM_ADDR_CTRL     = 0;
    localparam int unsigned TAM_ADDR_MAP      = 1;
    localparam int unsigned TAM_ADDR_IVL_BASE = 4;

    // Increment with wrap for round-robin pointers
    function automatic int tam_wrap_inc(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/tam_cfg.sv
module tam_cfg
    import tam_pkg::*;
#(
    parameter int N_REQ  = 8,
    parameter int N_GRP  = 4,
    parameter int GRP_W  = 2,
    parameter int IVL_W  = 12,
    parameter int CFG_AW = 3,
    parameter int CFG_DW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [CFG_DW-1:0]        cfg_wdata,
    output logic                     en,
    output logic [N_REQ*GRP_W-1:0]   grp_map,
    output logic [N_GRP*IVL_W-1:0]   ivl,
    output logic [N_GRP-1:0]         restart
);
    localparam int MAP_W = N_REQ * GRP_W;

    typedef struct packed {
        logic                              en;
        logic [N_REQ-1:0][GRP_W-1:0]       map;
        logic [N_GRP-1:0][IVL_W-1:0]       ivl;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        restart = '0;
        if (cfg_we) begin
            if (cfg_addr == CFG_AW'(TAM_ADDR_CTRL))
                st_d.en = cfg_wdata[0];
            if (cfg_addr == CFG_AW'(TAM_ADDR_MAP))
                st_d.map = cfg_wdata[MAP_W-1:0];
            for (int g = 0; g < N_GRP; g++) begin
                if (cfg_addr == CFG_AW'(TAM_ADDR_IVL_BASE + g)) begin
                    st_d.ivl[g] = cfg_wdata[IVL_W-1:0];
                    restart[g]  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en      = st_q.en;
    assign grp_map = st_q.map;
    assign ivl     = st_q.ivl;

    // R10: a map write is visible in the following cycle
    a_r10_map_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_AW'(TAM_ADDR_MAP)) |=> (grp_map == $past(cfg_wdata[MAP_W-1:0])));

endmodule

// File: rtl/tam_bucket.sv
module tam_bucket #(
    parameter int N_RES   = 20,
    parameter int IVL_W   = 12,
    parameter int TOK_CAP = 2,
    parameter int CNT_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IVL_W-1:0]         ivl,
    input  logic                     restart,
    input  logic [N_RES-1:0]         congest,
    input  logic [N_RES-1:0]         take,
    output logic [N_RES*CNT_W-1:0]   cnt
);
    typedef struct packed {
        logic [IVL_W-1:0]                  timer;
        logic [N_RES-1:0]                  half;
        logic [N_RES-1:0][CNT_W-1:0]       cnt;
    } bkt_t;

    bkt_t             st_d, st_q;
    logic             tick;
    logic [N_RES-1:0] add;
    logic [CNT_W:0]   sum;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        add  = '0;
        sum  = '0;
        if (restart) begin
            st_d.timer = '0;
            st_d.half  = '0;
        end else if (ivl != '0) begin
            tick       = (st_q.timer >= ivl - 1'b1);
            st_d.timer = tick ? '0 : st_q.timer + 1'b1;
        end else begin
            st_d.timer = '0;
        end

        for (int r = 0; r < N_RES; r++) begin
            if (tick) begin
                add[r]       = ~congest[r] | st_q.half[r];
                st_d.half[r] = congest[r] & ~st_q.half[r];
            end
            sum = {1'b0, st_q.cnt[r]} + {{CNT_W{1'b0}}, add[r]};
            if (take[r] && sum != '0)
                sum = sum - 1'b1;
            if (sum > (CNT_W+1)'(TOK_CAP))
                sum = (CNT_W+1)'(TOK_CAP);
            st_d.cnt[r] = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    for (genvar r = 0; r < N_RES; r++) begin : g_chk
        // R6: bucket never exceeds its cap
        a_r6_token_cap: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[r] <= CNT_W'(TOK_CAP));
        // R7: a grant without a refill removes exactly one token
        a_r7_take_consumes: assert property (@(posedge clk) disable iff (!rst_n)
            (take[r] && !add[r] && st_q.cnt[r] != '0) |=> (st_q.cnt[r] == $past(st_q.cnt[r]) - 1'b1));
        // R5: a zero interval earns nothing
        a_r5_zero_ivl_no_gain: assert property (@(posedge clk) disable iff (!rst_n)
            (ivl == '0) |=> (st_q.cnt[r] <= $past(st_q.cnt[r])));
    end

endmodule

// File: rtl/tam_arb.sv
module tam_arb
    import tam_pkg::*;
#(
    parameter int N_REQ = 8,
    parameter int N_GRP = 4,
    parameter int GRP_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_REQ-1:0]         elig,
    input  logic [N_REQ*GRP_W-1:0]   grp_map,
    output logic [N_REQ-1:0]         gnt
);
    localparam int RR_W = $clog2(N_REQ);
    localparam int GP_W = $clog2(N_GRP);

    typedef struct packed {
        logic [N_GRP-1:0][RR_W-1:0] rr;
        logic [GP_W-1:0]            gp;
    } arb_t;

    arb_t             st_d, st_q;
    logic [N_GRP-1:0] has;
    int               win [N_GRP];
    int               idx;
    int               gi;
    int               sel;
    logic             found;

    always_comb begin
        st_d  = st_q;
        gnt   = '0;
        idx   = 0;
        gi    = 0;
        sel   = 0;
        found = 1'b0;
        // Per-group winner, searched from that group's pointer
        for (int g = 0; g < N_GRP; g++) begin
            has[g] = 1'b0;
            win[g] = 0;
            for (int k = 0; k < N_REQ; k++) begin
                idx = int'(st_q.rr[g]) + k;
                if (idx >= N_REQ) idx = idx - N_REQ;
                if (!has[g] && elig[idx] && grp_map[idx*GRP_W +: GRP_W] == GRP_W'(g)) begin
                    has[g] = 1'b1;
                    win[g] = idx;
                end
            end
        end
        // One group served per cycle, rotating
        for (int k = 0; k < N_GRP; k++) begin
            gi = int'(st_q.gp) + k;
            if (gi >= N_GRP) gi = gi - N_GRP;
            if (!found && has[gi]) begin
                found = 1'b1;
                sel   = gi;
            end
        end
        if (found) begin
            gnt[win[sel]] = 1'b1;
            st_d.rr[sel]  = RR_W'(tam_wrap_inc(win[sel], N_REQ));
            st_d.gp       = GP_W'(tam_wrap_inc(sel, N_GRP));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: arbiter only grants eligible requesters
    a_r3_arb_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~elig) == '0);

endmodule

// File: rtl/tok_alloc_mgr.sv
module tok_alloc_mgr #(
    parameter int N_REQ   = 8,
    parameter int N_GRP   = 4,
    parameter int N_RES   = 20,
    parameter int TOK_CAP = 2,
    parameter int IVL_W   = 12,
    parameter int CFG_AW  = 3,
    parameter int CFG_DW  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [CFG_DW-1:0]             cfg_wdata,
    input  logic [N_REQ-1:0]              req_valid,
    input  logic [N_REQ*$clog2(N_RES)-1:0] req_res,
    input  logic [N_RES-1:0]              congest,
    output logic [N_REQ-1:0]              gnt
);
    localparam int RES_W = $clog2(N_RES);
    localparam int GRP_W = $clog2(N_GRP);
    localparam int CNT_W = $clog2(TOK_CAP + 1);

    logic                                 en;
    logic [N_REQ*GRP_W-1:0]               grp_map;
    logic [N_GRP*IVL_W-1:0]               ivl;
    logic [N_GRP-1:0]                     restart;
    logic [N_GRP-1:0][N_RES*CNT_W-1:0]    cnt;
    logic [N_GRP-1:0][N_RES-1:0]          take;
    logic [N_REQ-1:0]                     elig;
    logic [N_REQ-1:0]                     arb_gnt;
    logic [GRP_W-1:0]                     gsel;
    logic [RES_W-1:0]                     rsel;

    tam_cfg #(
        .N_REQ(N_REQ), .N_GRP(N_GRP), .GRP_W(GRP_W),
        .IVL_W(IVL_W), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .en(en), .grp_map(grp_map), .ivl(ivl),
        .restart(restart)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_bkt
        tam_bucket #(
            .N_RES(N_RES), .IVL_W(IVL_W), .TOK_CAP(TOK_CAP), .CNT_W(CNT_W)
        ) u_bkt (
            .clk(clk), .rst_n(rst_n), .ivl(ivl[g*IVL_W +: IVL_W]),
            .restart(restart[g]), .congest(congest), .take(take[g]),
            .cnt(cnt[g])
        );
    end

    // Token lookup per requester and token spending for the winner
    always_comb begin
        elig = '0;
        take = '0;
        gsel = '0;
        rsel = '0;
        for (int i = 0; i < N_REQ; i++) begin
            gsel = grp_map[i*GRP_W +: GRP_W];
            rsel = req_res[i*RES_W +: RES_W];
            if (int'(rsel) < N_RES) begin
                elig[i] = en && req_valid[i] && (cnt[gsel][int'(rsel)*CNT_W +: CNT_W] != '0);
                if (arb_gnt[i])
                    take[gsel][rsel] = 1'b1;
            end
        end
    end

    tam_arb #(
        .N_REQ(N_REQ), .N_GRP(N_GRP), .GRP_W(GRP_W)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .elig(elig), .grp_map(grp_map), .gnt(arb_gnt)
    );

    assign gnt = en ? arb_gnt : req_valid;

    // R4: a single grant per cycle while managing
    a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> $onehot0(gnt));
    // R3: never a grant without a request
    a_r3_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req_valid) == '0);

endmodule

// File: tb/tok_alloc_mgr_tb.sv
`timescale 1ns/1ps
module tok_alloc_mgr_tb;

    localparam int NR = 8;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic [NR-1:0] req_valid = '0;
    logic [NR*RW-1:0] req_res = '0;
    logic [19:0]   congest = '0;
    logic [NR-1:0] gnt;

    int    checks = 0;
    int    errors = 0;
    bit    sb_on = 1'b0;
    bit    done = 1'b0;
    string tag = "R3";
    int    exp_q [$];

    always #10 clk = ~clk;

    tok_alloc_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_res(req_res),
        .congest(congest), .gnt(gnt)
    );

    task automatic chk(input bit ok, input string t, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", t, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_req(input int i, input int res);
        req_res[i*RW +: RW] = RW'(res);
        req_valid[i] = 1'b1;
    endtask

    task automatic expect_gnt(input int i);
        exp_q.push_back(i);
    endtask

    task automatic drain(input string t);
        chk(exp_q.size() == 0, t, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Monitor: pops expected grants and compares
    always @(negedge clk) begin
        if (rst_n && sb_on && gnt != '0) begin
            int who;
            who = -1;
            for (int k = NR-1; k >= 0; k--) if (gnt[k]) who = k;
            chk($onehot(gnt), "R4 one grant per cycle", int'(gnt), 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, {tag, " unexpected grant"}, who, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(who == e, {tag, " grant order"}, who, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: idle after reset
        @(negedge clk);
        chk(gnt == '0, "R2 reset no grant", int'(gnt), 0);
        // R1: bypass after reset
        @(posedge clk); #1 req_valid = 8'hA5;
        @(negedge clk);
        chk(gnt == 8'hA5, "R1 bypass", int'(gnt), 'hA5);
        @(posedge clk); #1 req_valid = '0;

        // R2/R3: enabled, empty buckets, nothing granted
        cfg_write(3'd0, 16'h0001);
        sb_on = 1'b1; tag = "R2 R3 empty buckets";
        for (int i = 0; i < NR; i++) set_req(i, i);
        set_req(1, 25);
        repeat (10) @(posedge clk); #1;
        drain("R2 empty buckets");
        req_valid = '0;

        // Groups: 0,1,2->g0; 3,4->g1; 5,6->g2; 7->g3
        cfg_write(3'd1, 16'hE940);
        cfg_write(3'd4, 16'd8);
        repeat (30) @(posedge clk); #1;
        cfg_write(3'd4, 16'd0);

        // R6 cap, R7 consume, R8 order, R5 frozen refill
        tag = "R6 R7 R8 capped bucket";
        expect_gnt(0); expect_gnt(1);
        set_req(0, 5); set_req(1, 5); set_req(2, 5); set_req(3, 5);
        repeat (10) @(posedge clk); #1;
        drain("R6 two tokens");
        req_valid = '0;

        // R8 rotation continues after requester 1
        tag = "R8 rotation";
        expect_gnt(2); expect_gnt(0);
        set_req(0, 6); set_req(2, 6);
        repeat (6) @(posedge clk); #1;
        drain("R8 rotation");
        req_valid = '0;

        // R5 exact refill rate, group 1 interval 6
        tag = "R5 refill rate";
        set_req(3, 9);
        repeat (3) @(posedge clk); #1;
        for (int k = 0; k < 9; k++) expect_gnt(3);
        cfg_write(3'd5, 16'd6);
        repeat (56) @(posedge clk); #1;
        req_valid = '0;
        drain("R5 refill rate");
        cfg_write(3'd5, 16'd0);

        // R9 congestion halves resource 10 only; R8/R4 interleave in g2
        tag = "R9 congestion";
        congest[10] = 1'b1;
        set_req(5, 10); set_req(6, 11);
        expect_gnt(6);
        for (int k = 0; k < 4; k++) begin
            expect_gnt(5); expect_gnt(6); expect_gnt(6);
        end
        cfg_write(3'd6, 16'd6);
        repeat (56) @(posedge clk); #1;
        req_valid = '0;
        drain("R9 congestion");
        cfg_write(3'd6, 16'd0);
        congest = '0;

        // R10 remap takes effect next cycle, group 0 tokens reused
        tag = "R10 remap";
        set_req(7, 8);
        repeat (5) @(posedge clk); #1;
        expect_gnt(7); expect_gnt(7);
        cfg_write(3'd1, 16'h2940);
        @(negedge clk);
        chk(gnt == 8'h80, "R10 next cycle", int'(gnt), 'h80);
        repeat (6) @(posedge clk); #1;
        drain("R10 remap");
        req_valid = '0;

        // R1: bypass again
        sb_on = 1'b0;
        cfg_write(3'd0, 16'h0000);
        req_valid = 8'hFF;
        @(negedge clk);
        chk(gnt == 8'hFF, "R1 bypass after disable", int'(gnt), 'hFF);
        @(posedge clk); #1 req_valid = '0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule